// File: doc/BRIEF.md
# CAN Transceiver Mode Controller

This block chooses the operating mode of an on-chip CAN transceiver. It takes a two-bit system mode field, a transceiver standby bit and the already-synchronised undervoltage comparator output of the transceiver supply (the V2 regulator, or an external source tied to the same pin when the regulator is switched off). From these it drives the regulator enable, the transmitter/receiver enable, the bus wake-detect enable and the split-voltage driver enable.

It also supervises the supply. A status bit shows supply health while the system is in Normal mode and reads 1 otherwise. A sticky interrupt flag catches each loss of the supply and holds until software clears it with a write-one-to-clear pulse. Every output comes straight from a flop, so the enables cannot glitch. Each output reflects the inputs sampled at the previous rising clock edge.

Top module: `can_xcvr_mode_ctrl`

## Requirements
- R1: `v2_en` is 1 exactly when the sampled `sys_mode` is 2'b11. Mode 2'b10 is Normal with the regulator off, so `v2_en` is 0 there.
- R2: `trx_en` and `split_en` are both 1 only when `sys_mode` is 2'b10 or 2'b11, `stby_bit` is 0 and `v2_uv` is 0 (Active mode).
- R3: When `stby_bit` is 1, the transceiver is in Lowpower mode for every `sys_mode` value: `wake_en` is 1, and `trx_en` and `split_en` are 0.
- R4: When `sys_mode` is 2'b00 or 2'b01 and `stby_bit` is 0, the transceiver is Off: `trx_en`, `wake_en` and `split_en` are all 0.
- R5: In Normal mode with `stby_bit` 0 and `v2_uv` 1, `trx_en`, `split_en` and `wake_en` are 0. On the first clock edge that samples `v2_uv` back at 0, the outputs turn Active.
- R6: `v2_status` equals the inverse of `v2_uv` when `sys_mode` is 2'b10 or 2'b11, and reads 1 when `sys_mode` is 2'b00 or 2'b01.
- R7: `v2_uv_irq` sets on a falling edge of supply-good, meaning `v2_uv` sampled at 0 at one edge and at 1 at the next. Holding `v2_uv` at 1 does not set it again after a clear.
- R8: `v2_uv_irq` stays set until a cycle with `irq_clr` at 1 clears it. If a new supply loss lands in the same cycle as a clear, the flag stays set.
- R9: While `rst` is high, and at the first edge after it, `v2_en`, `trx_en`, `wake_en`, `split_en` and `v2_uv_irq` are 0 and `v2_status` is 1. Supply-good history is reset to "not good", so a supply that is bad out of reset raises no interrupt.
- R10: Every output changes exactly one clock edge after the inputs that cause the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_mode | input | 2 | System mode: 00/01 Standby/Sleep, 10 Normal with V2 off, 11 Normal with V2 on |
| stby_bit | input | 1 | Transceiver standby request (1 = Lowpower with wake detection) |
| v2_uv | input | 1 | Synchronised V2-pin undervoltage comparator (1 = below threshold) |
| irq_clr | input | 1 | Write-one-to-clear pulse for the interrupt flag |
| v2_en | output | 1 | V2 regulator enable |
| trx_en | output | 1 | Transmitter/receiver enable |
| wake_en | output | 1 | Bus wake-detect enable |
| split_en | output | 1 | Split-voltage driver enable (0 = high impedance) |
| v2_status | output | 1 | Supply status, 1 outside Normal mode |
| v2_uv_irq | output | 1 | Sticky supply-loss interrupt flag |

## Verification
The bench holds Normal mode with the supply low to confirm the transmitter stays off. A design that gated only on mode and standby would drive the bus with no supply. The bench then checks that Active mode returns exactly one edge after recovery. It holds undervoltage across a clear to catch an interrupt that is level-sensitive, and it lands a supply loss on the clear cycle to catch a clear that swallows a fresh event. Setting standby in Standby mode and in Normal mode exposes designs that tie wake detection to the system mode. A final sweep of all input combinations catches a wrong status value outside Normal mode and a regulator enable decoded from a single bit.

// File: rtl/can_xcvr_pkg.sv
package can_xcvr_pkg;

    localparam int MODE_W = 2;

    localparam logic [MODE_W-1:0] SYS_NORMAL_V2ON = 2'b11;

    typedef enum logic [1:0] {
        XM_OFF    = 2'd0,
        XM_LOWPWR = 2'd1,
        XM_WAIT   = 2'd2,
        XM_ACTIVE = 2'd3
    } xcvr_mode_e;

    typedef struct packed {
        logic v2_en;
        logic trx_en;
        logic wake_en;
        logic split_en;
    } xcvr_ctl_t;

    localparam xcvr_ctl_t CTL_RESET = '{v2_en: 1'b0, trx_en: 1'b0,
                                        wake_en: 1'b0, split_en: 1'b0};

    function automatic logic is_normal(input logic [MODE_W-1:0] m);
        return m[MODE_W-1];
    endfunction

    function automatic xcvr_mode_e resolve_mode(input logic [MODE_W-1:0] m,
                                                input logic stby,
                                                input logic supply_ok);
        xcvr_mode_e r;
        if (stby)
            r = XM_LOWPWR;
        else if (!is_normal(m))
            r = XM_OFF;
        else if (supply_ok)
            r = XM_ACTIVE;
        else
            r = XM_WAIT;
        return r;
    endfunction

    function automatic xcvr_ctl_t ctl_from_mode(input xcvr_mode_e xm,
                                                input logic v2_on);
        xcvr_ctl_t c;
        c.v2_en    = v2_on;
        c.trx_en   = (xm == XM_ACTIVE);
        c.split_en = (xm == XM_ACTIVE);
        c.wake_en  = (xm == XM_LOWPWR);
        return c;
    endfunction

endpackage

// File: rtl/can_xcvr_mode_decode.sv
module can_xcvr_mode_decode
    import can_xcvr_pkg::*;
(
    input  logic [MODE_W-1:0] sys_mode,
    input  logic              stby_bit,
    input  logic              supply_ok,
    output xcvr_mode_e        next_mode,
    output xcvr_ctl_t         next_ctl
);

    always_comb begin
        next_mode = resolve_mode(sys_mode, stby_bit, supply_ok);
        next_ctl  = ctl_from_mode(next_mode, sys_mode == SYS_NORMAL_V2ON);
    end

endmodule

// File: rtl/can_xcvr_out_reg.sv
module can_xcvr_out_reg
    import can_xcvr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] sys_mode,
    input  logic              stby_bit,
    input  logic              v2_uv,
    input  xcvr_ctl_t         next_ctl,
    output xcvr_ctl_t         ctl_q
);

    always_ff @(posedge clk) begin
        if (rst)
            ctl_q <= CTL_RESET;
        else
            ctl_q <= next_ctl;
    end

    // R1: regulator enable follows the full two-bit code
    p_v2en_decode_r1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (ctl_q.v2_en == ($past(sys_mode) == 2'b11)));

    // R3: standby request means Lowpower in every system mode
    p_lowpower_r3: assert property (@(posedge clk) disable iff (rst)
        stby_bit |=> (ctl_q.wake_en && !ctl_q.trx_en && !ctl_q.split_en));

    // R4: Standby/Sleep without standby bit is fully off
    p_off_r4: assert property (@(posedge clk) disable iff (rst)
        (!sys_mode[1] && !stby_bit) |=>
        (!ctl_q.trx_en && !ctl_q.wake_en && !ctl_q.split_en));

    // R5: no transmitter while the supply is low
    p_wait_uv_r5: assert property (@(posedge clk) disable iff (rst)
        (sys_mode[1] && !stby_bit && v2_uv) |=>
        (!ctl_q.trx_en && !ctl_q.split_en && !ctl_q.wake_en));

    // R2: healthy Normal mode without standby turns Active
    p_active_r2: assert property (@(posedge clk) disable iff (rst)
        (sys_mode[1] && !stby_bit && !v2_uv) |=>
        (ctl_q.trx_en && ctl_q.split_en));

endmodule

// File: rtl/can_v2_supervisor.sv
module can_v2_supervisor
    import can_xcvr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic normal_mode,
    input  logic supply_ok,
    input  logic irq_clr,
    output logic v2_status,
    output logic v2_uv_irq
);

    logic ok_prev;
    logic ok_fall;

    assign ok_fall = ok_prev && !supply_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            ok_prev   <= 1'b0;
            v2_status <= 1'b1;
            v2_uv_irq <= 1'b0;
        end else begin
            ok_prev   <= supply_ok;
            v2_status <= normal_mode ? supply_ok : 1'b1;
            if (ok_fall)
                v2_uv_irq <= 1'b1;
            else if (irq_clr)
                v2_uv_irq <= 1'b0;
        end
    end

    // R6: status forced to 1 outside Normal mode
    p_status_idle_r6: assert property (@(posedge clk) disable iff (rst)
        !normal_mode |=> v2_status);

    // R7: a supply loss always sets the flag
    p_irq_set_r7: assert property (@(posedge clk) disable iff (rst)
        (ok_prev && !supply_ok) |=> v2_uv_irq);

    // R8: flag is sticky without a clear
    p_irq_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (v2_uv_irq && !irq_clr) |=> v2_uv_irq);

    // R7: a steady supply level never raises the flag from clear
    p_irq_no_level_r7: assert property (@(posedge clk) disable iff (rst)
        (!v2_uv_irq && (ok_prev == supply_ok)) |=> !v2_uv_irq);

endmodule

// File: rtl/can_xcvr_mode_ctrl.sv
module can_xcvr_mode_ctrl
    import can_xcvr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] sys_mode,
    input  logic       stby_bit,
    input  logic       v2_uv,
    input  logic       irq_clr,
    output logic       v2_en,
    output logic       trx_en,
    output logic       wake_en,
    output logic       split_en,
    output logic       v2_status,
    output logic       v2_uv_irq
);

    logic       supply_ok;
    xcvr_mode_e next_mode;
    xcvr_ctl_t  next_ctl;
    xcvr_ctl_t  ctl_q;

    assign supply_ok = !v2_uv;

    can_xcvr_mode_decode u_decode (
        .sys_mode  (sys_mode),
        .stby_bit  (stby_bit),
        .supply_ok (supply_ok),
        .next_mode (next_mode),
        .next_ctl  (next_ctl)
    );

    can_xcvr_out_reg u_outreg (
        .clk      (clk),
        .rst      (rst),
        .sys_mode (sys_mode),
        .stby_bit (stby_bit),
        .v2_uv    (v2_uv),
        .next_ctl (next_ctl),
        .ctl_q    (ctl_q)
    );

    can_v2_supervisor u_supv (
        .clk         (clk),
        .rst         (rst),
        .normal_mode (is_normal(sys_mode)),
        .supply_ok   (supply_ok),
        .irq_clr     (irq_clr),
        .v2_status   (v2_status),
        .v2_uv_irq   (v2_uv_irq)
    );

    assign v2_en    = ctl_q.v2_en;
    assign trx_en   = ctl_q.trx_en;
    assign wake_en  = ctl_q.wake_en;
    assign split_en = ctl_q.split_en;

    // R2: decoder never reports Active while the supply is bad
    p_decode_active_r2: assert property (@(posedge clk) disable iff (rst)
        (next_mode == XM_ACTIVE) |-> supply_ok);

    // R3: bus driver and wake detection never on together
    p_trx_wake_excl_r3: assert property (@(posedge clk) disable iff (rst)
        !(trx_en && wake_en));

endmodule

// File: tb/test_can_xcvr_mode_ctrl.sv
module test_can_xcvr_mode_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] sys_mode = 2'b00;
    logic       stby_bit = 1'b0;
    logic       v2_uv = 1'b0;
    logic       irq_clr = 1'b0;
    logic       v2_en, trx_en, wake_en, split_en, v2_status, v2_uv_irq;

    always #2 clk = ~clk;

    can_xcvr_mode_ctrl i_can_xcvr_mode_ctrl (
        .clk(clk), .rst(rst), .sys_mode(sys_mode), .stby_bit(stby_bit),
        .v2_uv(v2_uv), .irq_clr(irq_clr), .v2_en(v2_en), .trx_en(trx_en),
        .wake_en(wake_en), .split_en(split_en), .v2_status(v2_status),
        .v2_uv_irq(v2_uv_irq)
    );

    typedef struct {
        logic [5:0] exp;
        string      tag;
    } item_t;

    item_t sb_q[$];
    int    n_checks = 0;
    int    n_fail   = 0;
    logic  m_prev_ok = 1'b0;
    logic  m_irq     = 1'b0;
    bit    done      = 1'b0;

    // packed order: v2_en trx_en wake_en split_en v2_status v2_uv_irq
    function automatic logic [5:0] sample_outs();
        return {v2_en, trx_en, wake_en, split_en, v2_status, v2_uv_irq};
    endfunction

    task automatic check(input string tag, input logic [5:0] act,
                         input logic [5:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [1:0] m, input logic s, input logic uv,
                         input logic clr, input string tag);
        item_t it;
        logic act, nrm;
        @(negedge clk);
        sys_mode = m; stby_bit = s; v2_uv = uv; irq_clr = clr;
        nrm = m[1];
        act = nrm && !s && !uv;
        it.exp[5] = (m == 2'b11);
        it.exp[4] = act;
        it.exp[3] = s;
        it.exp[2] = act;
        it.exp[1] = nrm ? !uv : 1'b1;
        m_irq     = (m_prev_ok && uv) || (m_irq && !clr);
        it.exp[0] = m_irq;
        m_prev_ok = !uv;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // monitor: one item per rising edge, sampled 1 ns after it
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                check(it.tag, sample_outs(), it.exp);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R9 reset held", sample_outs(), 6'b000010);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check("R9 first edge out of reset", sample_outs(), 6'b000010);

        apply(2'b00, 1'b0, 1'b0, 1'b0, "R4 standby off");
        apply(2'b01, 1'b0, 1'b0, 1'b0, "R4 sleep off");
        apply(2'b10, 1'b0, 1'b0, 1'b0, "R2 R1 normal v2 off active");
        apply(2'b11, 1'b0, 1'b0, 1'b0, "R2 R1 normal v2 on active");
        apply(2'b11, 1'b1, 1'b0, 1'b0, "R3 lowpower in normal");
        apply(2'b00, 1'b1, 1'b0, 1'b0, "R3 lowpower in standby");
        apply(2'b11, 1'b0, 1'b0, 1'b0, "R10 back to active");
        apply(2'b11, 1'b0, 1'b1, 1'b0, "R5 R7 R6 supply lost");
        apply(2'b11, 1'b0, 1'b1, 1'b0, "R5 R8 held low sticky");
        apply(2'b11, 1'b0, 1'b1, 1'b1, "R8 clear while low");
        apply(2'b11, 1'b0, 1'b1, 1'b0, "R7 level does not reset flag");
        apply(2'b11, 1'b0, 1'b0, 1'b0, "R5 active on recovery");
        apply(2'b11, 1'b0, 1'b1, 1'b1, "R8 loss wins over clear");
        apply(2'b11, 1'b0, 1'b1, 1'b1, "R8 clear after loss");
        apply(2'b01, 1'b0, 1'b1, 1'b0, "R6 status 1 in sleep");
        apply(2'b10, 1'b0, 1'b1, 1'b0, "R6 R1 status 0 normal v2 off");

        for (int k = 0; k < 64; k++) begin
            logic [5:0] v;
            v = 6'(k);
            apply(v[1:0], v[2], v[3], v[4], "R10 R6 R1 sweep");
        end
        for (int k = 0; k < 32; k++) begin
            logic [4:0] v;
            v = 5'(31 - k);
            apply(v[1:0], v[2], v[3], v[4], "R10 R2 reverse sweep");
        end

        @(negedge clk);
        irq_clr = 1'b0;
        while (sb_q.size() > 0) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule